// File: doc/BRIEF.md
# Shared Bus Hold/Ready Controller

This block owns the external system bus of a controller that shares memory with an outside host. The host has one request pin. A control input sets what that pin means.

In hold mode, a high level on the pin asks for the bus. The block lets any bus cycle already running finish. It then stops driving the address, data and control lines by dropping their output enables. After that it raises an acknowledge, and the host waits for this before it starts its own transfers. When the host lowers the pin, the acknowledge falls first. One clock later the lines are driven again. Any internal request that arrived while the bus was away was held back, and it runs at that point.

In ready mode, the same pin is a wait-state input. While it is low, the last clock of the current bus cycle repeats, and completion is held back. The acknowledge can be routed onto a pin that it shares with a general-purpose output. The internal CPU side is a level request with a one-clock done pulse.

Top module: `bus_share_ctrl`

## Requirements
- R1: The host pin passes through two synchronising flops. In hold mode with no cycle running, the acknowledge rises on the third rising clock edge after the pin goes high.
- R2: A mode input of 1 selects hold mode. A mode input of 0 selects ready mode. In ready mode a high pin never releases the bus. In hold mode a low pin never adds wait states.
- R3: While the bus is released, addr_oe, ctl_oe and data_oe are all 0 (high impedance) and hold_ack is 1. The acknowledge is never 1 while the bus is driven.
- R4: A hold request is honoured only at a cycle boundary. A cycle already running completes with its full strobe length, and then the bus is released.
- R5: When the request is removed, hold_ack falls on the third edge after the pin falls. The enables return one clock later.
- R6: A CPU request made while the bus is released starts no cycle and is not lost. It completes after the bus is restored.
- R7: In ready mode, a bus cycle holds its strobe for max(CYC_LEN, N+2) clocks, where N is the number of clock periods after the request before the pin rises. cpu_done is held off until then.
- R8: ack_pin carries hold_ack when ack_pin_en is 1, and gpio_dout otherwise.
- R9: A bus cycle holds strobe high for CYC_LEN clocks when no wait states are added, then gives a single one-clock cpu_done pulse. Read data is captured from bus_din at completion. data_oe is 1 only during write cycles.
- R10: After reset, hold_ack, strobe and cpu_done are 0, and the enables are 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| hold_mode | input | 1 | 1 = pin is hold request, 0 = pin is ready |
| host_pin | input | 1 | Asynchronous hold/ready pin from host |
| ack_pin_en | input | 1 | Route acknowledge onto shared pin |
| gpio_dout | input | 1 | General-purpose value for shared pin |
| ack_pin | output | 1 | Shared pin output |
| hold_ack | output | 1 | Bus released acknowledge |
| cpu_req | input | 1 | Internal bus cycle request (level) |
| cpu_we | input | 1 | 1 = write cycle |
| cpu_addr | input | ADDR_W | Cycle address |
| cpu_wdata | input | DATA_W | Write data |
| cpu_done | output | 1 | One-clock completion pulse |
| cpu_rdata | output | DATA_W | Captured read data |
| bus_addr | output | ADDR_W | Address lines |
| bus_dout | output | DATA_W | Data lines out |
| bus_din | input | DATA_W | Data lines in |
| bus_we | output | 1 | Write indicator |
| bus_strb | output | 1 | Cycle strobe |
| addr_oe | output | 1 | Address output enable |
| data_oe | output | 1 | Data output enable |
| ctl_oe | output | 1 | Control output enable |

## Verification
The bench sweeps the moment the ready pin rises against a fixed cycle length. This shows that wait states start only once the base length is used up, and that a design which got the synchroniser depth wrong would shift every strobe count by one. A hold raised on the same clock as a CPU request checks that the cycle keeps its full strobe and that done arrives before the acknowledge. A design that floated the bus mid-cycle would cut the strobe short. A request made during release has to appear after restore. A design that dropped it would never pulse done, and one that ignored the stall would strobe a released bus. The bench also checks the one-clock gap between the acknowledge falling and the enables returning, plus mode isolation and the shared-pin mux.

// File: rtl/bus_share_pkg.sv
// Shared types for the bus hold/ready controller.
package bus_share_pkg;
    typedef enum logic [1:0] {
        ST_IDLE     = 2'd0,
        ST_FINISH   = 2'd1,
        ST_RELEASED = 2'd2,
        ST_RESTORE  = 2'd3
    } share_state_e;
endpackage

// File: rtl/pin_sync.sv
// Two-flop synchroniser for the asynchronous host pin.
// Assumes the pin is a level held for several clocks.
module pin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_async,
    output logic q_sync
);
    logic [STAGES-1:0] chain;

    // Shift the pin through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-2:0], d_async};
    end

    assign q_sync = chain[STAGES-1];
endmodule

// File: rtl/bus_cycle_engine.sv
// Runs one bus cycle per start: the strobe stays high for CYC_LEN clocks,
// and the last clock repeats while ready is low. Assumes start is given
// only when the engine is idle.
module bus_cycle_engine #(
    parameter int ADDR_W  = 16,
    parameter int DATA_W  = 8,
    parameter int CYC_LEN = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              ready,
    input  logic              we_in,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic [DATA_W-1:0] wdata_in,
    input  logic [DATA_W-1:0] bus_din,
    output logic              busy,
    output logic              done,
    output logic [DATA_W-1:0] rdata,
    output logic [ADDR_W-1:0] addr_q,
    output logic [DATA_W-1:0] wdata_q,
    output logic              we_q
);
    localparam int CNT_W = (CYC_LEN > 1) ? $clog2(CYC_LEN) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(CYC_LEN - 1);

    logic [CNT_W-1:0] cnt;
    logic             at_last;

    assign at_last = (cnt == LAST);

    // Cycle sequencing: latch the request, count the clocks, stretch on not-ready.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy    <= 1'b0;
            done    <= 1'b0;
            cnt     <= '0;
            rdata   <= '0;
            addr_q  <= '0;
            wdata_q <= '0;
            we_q    <= 1'b0;
        end else begin
            done <= 1'b0;
            if (start) begin
                busy    <= 1'b1;
                cnt     <= '0;
                addr_q  <= addr_in;
                wdata_q <= wdata_in;
                we_q    <= we_in;
            end else if (busy) begin
                if (!at_last) begin
                    cnt <= cnt + 1'b1;
                end else if (ready) begin
                    busy <= 1'b0;
                    done <= 1'b1;
                    if (!we_q) rdata <= bus_din;
                end
            end
        end
    end

    // R9: done is a single-clock pulse
    p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R7: no completion while ready was low at the final clock
    p_wait_holds_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && at_last && !ready && !start) |=> (busy && !done));
endmodule

// File: rtl/hold_fsm.sv
// Bus ownership state machine. A hold is taken only when no cycle is
// running. The acknowledge is dropped for one clock before the bus
// is driven again.
module hold_fsm
    import bus_share_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic hold_req,
    input  logic busy,
    output logic bus_drive,
    output logic ack,
    output logic grant
);
    share_state_e state, nxt;

    // Next-state choice.
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:     if (hold_req) nxt = busy ? ST_FINISH : ST_RELEASED;
            ST_FINISH:   if (!hold_req) nxt = ST_IDLE;
                         else if (!busy) nxt = ST_RELEASED;
            ST_RELEASED: if (!hold_req) nxt = ST_RESTORE;
            ST_RESTORE:  nxt = ST_IDLE;
            default:     nxt = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    assign bus_drive = (state == ST_IDLE) || (state == ST_FINISH);
    assign ack       = (state == ST_RELEASED);
    assign grant     = (state == ST_IDLE) && !hold_req;

    // R3: acknowledge never coincides with a driven bus
    p_ack_released_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ack |-> !bus_drive);
    // R5: after acknowledge falls, outputs stay off one more clock
    p_restore_gap_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ack) |-> !bus_drive);
endmodule

// File: rtl/bus_share_ctrl.sv
// Top level of the shared-bus hold/ready controller. Connects the pin
// synchroniser, the ownership state machine and the cycle engine. Output
// enables low mean the pads are high impedance.
module bus_share_ctrl #(
    parameter int ADDR_W  = 16,
    parameter int DATA_W  = 8,
    parameter int CYC_LEN = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hold_mode,
    input  logic              host_pin,
    input  logic              ack_pin_en,
    input  logic              gpio_dout,
    output logic              ack_pin,
    output logic              hold_ack,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic              cpu_done,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_dout,
    input  logic [DATA_W-1:0] bus_din,
    output logic              bus_we,
    output logic              bus_strb,
    output logic              addr_oe,
    output logic              data_oe,
    output logic              ctl_oe
);
    logic pin_s, hold_req, ready, busy, drive, grant, start;

    pin_sync #(.STAGES(2)) u_sync (
        .clk(clk), .rst_n(rst_n), .d_async(host_pin), .q_sync(pin_s)
    );

    assign hold_req = hold_mode & pin_s;
    assign ready    = hold_mode | pin_s;

    hold_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .hold_req(hold_req), .busy(busy),
        .bus_drive(drive), .ack(hold_ack), .grant(grant)
    );

    assign start = grant && cpu_req && !busy && !cpu_done;

    bus_cycle_engine #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CYC_LEN(CYC_LEN)) u_eng (
        .clk(clk), .rst_n(rst_n), .start(start), .ready(ready),
        .we_in(cpu_we), .addr_in(cpu_addr), .wdata_in(cpu_wdata),
        .bus_din(bus_din), .busy(busy), .done(cpu_done), .rdata(cpu_rdata),
        .addr_q(bus_addr), .wdata_q(bus_dout), .we_q(bus_we)
    );

    assign bus_strb = busy;
    assign addr_oe  = drive;
    assign ctl_oe   = drive;
    assign data_oe  = drive & busy & bus_we;
    assign ack_pin  = ack_pin_en ? hold_ack : gpio_dout;

    // R4: a running cycle is never cut off by a release
    p_no_float_cycle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> drive);
    // R6: no cycle starts while the bus is away
    p_stall_released_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !drive |=> !$rose(busy));
    // R2: ready mode never releases the bus
    p_ready_no_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !hold_mode && $stable(hold_mode) |=> !hold_ack || $past(hold_ack));
endmodule

// File: tb/bus_share_ctrl_tb.sv
module bus_share_ctrl_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 16, DW = 8, L = 3;

    logic clk = 0, rst_n = 0;
    logic hold_mode = 1, host_pin = 0, ack_pin_en = 0, gpio_dout = 0;
    logic ack_pin, hold_ack, cpu_req = 0, cpu_we = 0, cpu_done;
    logic [AW-1:0] cpu_addr = '0, bus_addr;
    logic [DW-1:0] cpu_wdata = '0, cpu_rdata, bus_dout, bus_din = '0;
    logic bus_we, bus_strb, addr_oe, data_oe, ctl_oe;

    int checks = 0, fails = 0, cyc = 0;
    bit hung = 0;

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    bus_share_ctrl #(.ADDR_W(AW), .DATA_W(DW), .CYC_LEN(L)) dut_i (.*);

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Run one cycle; pin rises after n negedges if n >= 0. Returns strobe clocks.
    task automatic run_cycle(input bit we, input int n, output int strb, output bit got);
        int k = 0;
        strb = 0; got = 0;
        cpu_we = we; cpu_req = 1;
        if (n == 0) host_pin = 1;
        while (k < 60) begin
            @(negedge clk); k++;
            if (cpu_done) begin got = 1; cpu_req = 0; break; end
            if (bus_strb) strb++;
            if (k == n) host_pin = 1;
        end
        cpu_req = 0;
    endtask

    initial begin
        int s, w;
        bit g, seen_done;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R10 reset state
        check(!hold_ack && !bus_strb && !cpu_done, "R10", {hold_ack, bus_strb, cpu_done}, 0);
        check(addr_oe && ctl_oe, "R10", {addr_oe, ctl_oe}, 3);

        // R9 plain write then read in hold mode with pin low (R2: no waits)
        cpu_addr = 16'h1234; cpu_wdata = 8'h5A;
        cpu_req = 1; cpu_we = 1;
        @(negedge clk);
        check(data_oe && bus_strb && bus_dout == 8'h5A, "R9", data_oe, 1);
        cpu_req = 0;
        while (!cpu_done && cyc < 1000) @(negedge clk);
        @(negedge clk);
        check(!cpu_done, "R9", cpu_done, 0);
        bus_din = 8'hA5;
        run_cycle(0, -1, s, g);
        check(g && s == L, "R9", s, L);
        check(cpu_rdata == 8'hA5, "R9", cpu_rdata, 8'hA5);
        check(!data_oe, "R9", data_oe, 0);

        // R7 ready-mode sweep of pin release time
        hold_mode = 0;
        for (int n = 0; n <= 6; n++) begin
            host_pin = 0;
            repeat (4) @(negedge clk);
            run_cycle(0, n, s, g);
            w = (L > n + 2) ? L : n + 2;
            check(g && s == w, "R7", s, w);
        end
        // R2 ready mode: high pin never acks
        host_pin = 1;
        repeat (6) @(negedge clk);
        check(!hold_ack && addr_oe, "R2", hold_ack, 0);

        // R1/R3/R5 hold latency and release
        host_pin = 0; hold_mode = 1;
        repeat (4) @(negedge clk);
        host_pin = 1;
        repeat (2) @(negedge clk);
        check(!hold_ack, "R1", hold_ack, 0);
        @(negedge clk);
        check(hold_ack, "R1", hold_ack, 1);
        check(!addr_oe && !ctl_oe && !data_oe, "R3", {addr_oe, ctl_oe, data_oe}, 0);
        // R8 shared pin mux
        ack_pin_en = 1; gpio_dout = 0; #1;
        check(ack_pin == 1, "R8", ack_pin, 1);
        ack_pin_en = 0; #1;
        check(ack_pin == 0, "R8", ack_pin, 0);
        gpio_dout = 1; #1;
        check(ack_pin == 1, "R8", ack_pin, 1);
        // R6 stall during release
        cpu_req = 1; cpu_we = 0;
        s = 0; seen_done = 0;
        repeat (5) begin @(negedge clk); if (bus_strb) s++; if (cpu_done) seen_done = 1; end
        check(s == 0 && !seen_done, "R6", s, 0);
        host_pin = 0;
        repeat (3) @(negedge clk);
        check(!hold_ack && !addr_oe, "R5", addr_oe, 0);
        @(negedge clk);
        check(addr_oe && ctl_oe, "R5", addr_oe, 1);
        g = 0;
        repeat (20) begin @(negedge clk); if (cpu_done) begin g = 1; cpu_req = 0; end end
        cpu_req = 0;
        check(g, "R6", g, 1);

        // R4 hold raised together with a request
        repeat (3) @(negedge clk);
        cpu_req = 1; host_pin = 1;
        s = 0; seen_done = 0;
        while (!hold_ack && cyc < 5000) begin
            @(negedge clk);
            if (bus_strb) s++;
            if (cpu_done) begin seen_done = 1; cpu_req = 0; end
        end
        check(s == L, "R4", s, L);
        check(seen_done, "R4", seen_done, 1);
        host_pin = 0;
        repeat (6) @(negedge clk);
        check(!hold_ack && addr_oe, "R5", hold_ack, 0);

        if (hung) check(0, "watchdog", cyc, 0);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        fails++; checks++;
        $display("FAIL watchdog actual=%0d expected=0", cyc);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule